// File: doc/BRIEF.md
# Address-monitor wait wakeup controller

This block is the per-core hardware behind an arm-then-wait pair of operations. An arm command records the cache line that holds a watched address and sets an armed flag. A later wait command asks for a low-power sub-state. If the core is armed, the block holds that sub-state on its power-state output until something ends the wait. The wait ends on a write-back store by a processor agent to any byte of the watched line, on an interrupt, or when a countdown expires. The block then reports the reason on a one-hot wake-cause output for a single cycle.

The requested sub-state is limited in three ways. A request made at non-zero privilege cannot go below the first halt state. The user-mode variant cannot go below its second sub-state. A control bit can pull that limit up to the lightest sub-state. A control value also sets an OS maximum wait time. The effective countdown is the smaller of that maximum and the wait's own deadline.

Software must recheck its condition after every wake, because a wake can have several causes. A wait issued without a valid arm returns at once and leaves the power state untouched.

Top module: `linewatch_wake`

## Requirements
- R1: After reset, `pstate_o` is 0 (active), `sleeping_o` is 0, `armed_o` is 0 and `wake_valid_o` is 0.
- R2: An arm command outside a wait stores the line number (address bits above the line offset) and drives `armed_o` to 1 from the next cycle.
- R3: A wait accepted while armed drives `sleeping_o` to 1 and `pstate_o` to the resolved state from the next cycle. The state codes are 0 active, 1 light sub-state, 2 deeper sub-state, 3 halt, and 4 to 7 deeper sleep states. A request of 0 resolves to 1.
- R4: A wait issued while not armed leaves `sleeping_o` and `pstate_o` at 0. In the next cycle it gives one wake pulse with the not-armed cause.
- R5: A store with `snoop_wb_i` and `snoop_cpu_i` set, to any byte of the armed line, ends the wait with the monitor cause. This also applies when the store arrives in the same cycle as the wait command. The wake-cause bits are: bit 0 monitor hit, bit 1 interrupt, bit 2 timer, bit 3 not armed.
- R6: A store that is not write-back, comes from a non-processor agent, or falls in another line does not end the wait.
- R7: An unmasked interrupt always ends the wait with the interrupt cause. A masked interrupt ends it only when the wait's break flag was 1.
- R8: A wait at non-zero privilege that requests a state above 3 is resolved to state 3.
- R9: A user-variant wait is capped at state 2. When `cfg_lite_i` is 1, it is capped at state 1.
- R10: The countdown is the wait's deadline when the wait is timed. When `cfg_max_time_i` is non-zero it is the OS maximum, or the smaller of the two if both apply. With neither, there is no countdown. The wait ends with the timer cause one cycle after the tick that brings the countdown to zero.
- R11: A wake pulse lasts one cycle, with `pstate_o` back at 0 and `armed_o` cleared. If several causes arrive in the same cycle, monitor hit wins over interrupt, and interrupt wins over timer.
- R12: A matching store between the arm and the wait clears `armed_o`, so the next wait returns at once with the not-armed cause.
- R13: Arm and wait commands issued while sleeping are ignored: they change neither the power state nor the armed flag that remains after the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid_i | input | 1 | Arm command strobe |
| arm_addr_i | input | ADDR_W | Address to watch |
| wait_valid_i | input | 1 | Wait command strobe |
| wait_state_i | input | 3 | Requested power state code |
| wait_brk_i | input | 1 | Masked interrupts may end this wait |
| wait_timed_i | input | 1 | Wait carries a deadline |
| wait_deadline_i | input | TIME_W | Deadline in ticks |
| wait_user_i | input | 1 | User-mode variant of the wait |
| wait_priv_i | input | 1 | Wait issued at non-zero privilege |
| cfg_lite_i | input | 1 | Cap user waits at the light sub-state |
| cfg_max_time_i | input | TIME_W | OS maximum wait in ticks, 0 = none |
| snoop_valid_i | input | 1 | Store observed on the bus |
| snoop_wb_i | input | 1 | Store is write-back |
| snoop_cpu_i | input | 1 | Store comes from a processor agent |
| snoop_addr_i | input | ADDR_W | Store address |
| irq_unmasked_i | input | 1 | Unmasked interrupt pending |
| irq_masked_i | input | 1 | Masked interrupt pending |
| tick_i | input | 1 | Time-stamp-rate tick |
| pstate_o | output | 3 | Current power state code |
| sleeping_o | output | 1 | A wait is in progress |
| armed_o | output | 1 | An address line is armed |
| wake_valid_o | output | 1 | One-cycle wake report |
| wake_cause_o | output | 4 | One-hot wake cause |

## Verification
The assertions check, on every cycle, that a wake report carries exactly one cause, and that the cause is zero when no report is made. They also check that a wake leaves the core disarmed, that a sleeping core always holds a non-active state while an active one holds state 0, and that a not-armed report never follows a real sleep. They further check that the privilege and user caps hold on each entry into sleep. Only the bench scenarios can show the following: which stores fall inside the line, the exact tick on which the countdown fires, how the OS maximum combines with the deadline, the masked-interrupt break flag, cause priority when events collide, and that commands issued during sleep are ignored.

// File: rtl/linewatch_pkg.sv
package linewatch_pkg;

    // power state codes
    localparam logic [2:0] PS_RUN  = 3'd0;
    localparam logic [2:0] PS_LITE = 3'd1;
    localparam logic [2:0] PS_SUB2 = 3'd2;
    localparam logic [2:0] PS_HALT = 3'd3;

    // wake cause bit positions
    localparam int CZ_MON   = 0;
    localparam int CZ_IRQ   = 1;
    localparam int CZ_TMR   = 2;
    localparam int CZ_NOARM = 3;
    localparam int CZ_W     = 4;

    typedef logic [CZ_W-1:0] cause_t;

endpackage

// File: rtl/lw_line_match.sv
module lw_line_match #(
    parameter int ADDR_W = 32,
    parameter int OFS    = 6
) (
    input  logic [ADDR_W-1:0]     snoop_addr_i,
    input  logic [ADDR_W-OFS-1:0] line_i,
    output logic                  hit_o
);
    logic unused_low;

    // byte offset inside the line never matters (R5)
    assign unused_low = ^snoop_addr_i[OFS-1:0];
    assign hit_o      = (snoop_addr_i[ADDR_W-1:OFS] == line_i);

endmodule

// File: rtl/lw_state_clamp.sv
module lw_state_clamp
    import linewatch_pkg::*;
(
    input  logic [2:0] req_i,
    input  logic       priv_i,
    input  logic       user_i,
    input  logic       lite_i,
    output logic [2:0] state_o
);
    logic [2:0] s0, s1, cap;

    always_comb begin
        // a request for "active" still enters the lightest sub-state (R3)
        s0  = (req_i == PS_RUN) ? PS_LITE : req_i;
        // non-zero privilege: nothing deeper than halt (R8)
        s1  = (priv_i && s0 > PS_HALT) ? PS_HALT : s0;
        // user variant: sub-state cap, tightened by the control bit (R9)
        cap = lite_i ? PS_LITE : PS_SUB2;
        state_o = (user_i && s1 > cap) ? cap : s1;
    end

endmodule

// File: rtl/lw_wait_timer.sv
module lw_wait_timer #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              timed_i,
    input  logic [TIME_W-1:0] deadline_i,
    input  logic [TIME_W-1:0] os_max_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              clear_i,
    output logic              expired_o
);
    typedef struct packed {
        logic              en;
        logic [TIME_W-1:0] rem;
    } tmr_t;

    tmr_t tq, td;
    logic os_on;

    assign os_on = (os_max_i != '0);

    always_comb begin
        td = tq;
        if (load_i) begin
            td.en = timed_i | os_on;
            if (timed_i && os_on && (os_max_i < deadline_i))
                td.rem = os_max_i;
            else if (timed_i)
                td.rem = deadline_i;
            else
                td.rem = os_max_i;
        end else if (clear_i) begin
            td.en  = 1'b0;
            td.rem = '0;
        end else if (run_i && tq.en && tick_i && (tq.rem != '0)) begin
            td.rem = tq.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    // R10: countdown reached zero while a timed wait runs
    assign expired_o = run_i && tq.en && (tq.rem == '0);

    a_r10_load_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && timed_i) |=> tq.en);

endmodule

// File: rtl/linewatch_wake.sv
module linewatch_wake
    import linewatch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int TIME_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic              wait_valid_i,
    input  logic [2:0]        wait_state_i,
    input  logic              wait_brk_i,
    input  logic              wait_timed_i,
    input  logic [TIME_W-1:0] wait_deadline_i,
    input  logic              wait_user_i,
    input  logic              wait_priv_i,
    input  logic              cfg_lite_i,
    input  logic [TIME_W-1:0] cfg_max_time_i,
    input  logic              snoop_valid_i,
    input  logic              snoop_wb_i,
    input  logic              snoop_cpu_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic              irq_unmasked_i,
    input  logic              irq_masked_i,
    input  logic              tick_i,
    output logic [2:0]        pstate_o,
    output logic              sleeping_o,
    output logic              armed_o,
    output logic              wake_valid_o,
    output logic [3:0]        wake_cause_o
);
    localparam int OFS    = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFS;

    typedef struct packed {
        logic              armed;
        logic [LINE_W-1:0] line;
        logic              sleep;
        logic              brk;
        logic [2:0]        pstate;
        logic              wake_v;
        cause_t            cause;
    } ctl_t;

    ctl_t q, d;

    logic       line_eq, store_hit, tmr_exp, wake_now;
    logic [2:0] eff_state;
    logic       tmr_load, tmr_clear;
    logic       unused_arm_low;

    assign unused_arm_low = ^arm_addr_i[OFS-1:0];

    lw_line_match #(.ADDR_W(ADDR_W), .OFS(OFS)) u_match (
        .snoop_addr_i (snoop_addr_i),
        .line_i       (q.line),
        .hit_o        (line_eq)
    );

    lw_state_clamp u_clamp (
        .req_i   (wait_state_i),
        .priv_i  (wait_priv_i),
        .user_i  (wait_user_i),
        .lite_i  (cfg_lite_i),
        .state_o (eff_state)
    );

    lw_wait_timer #(.TIME_W(TIME_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .timed_i    (wait_timed_i),
        .deadline_i (wait_deadline_i),
        .os_max_i   (cfg_max_time_i),
        .run_i      (q.sleep),
        .tick_i     (tick_i),
        .clear_i    (tmr_clear),
        .expired_o  (tmr_exp)
    );

    // only write-back stores by processor agents to the armed line count (R5, R6)
    assign store_hit = snoop_valid_i && snoop_wb_i && snoop_cpu_i && line_eq && q.armed;

    assign wake_now  = q.sleep && (store_hit || irq_unmasked_i ||
                                   (irq_masked_i && q.brk) || tmr_exp);
    assign tmr_load  = !q.sleep && wait_valid_i && q.armed && !store_hit;
    assign tmr_clear = wake_now;

    always_comb begin
        d        = q;
        d.wake_v = 1'b0;
        d.cause  = '0;
        if (!q.sleep) begin
            if (wait_valid_i) begin
                if (!q.armed) begin
                    // R4: no armed line, power state untouched
                    d.wake_v          = 1'b1;
                    d.cause[CZ_NOARM] = 1'b1;
                end else if (store_hit) begin
                    // R5: store lands together with the wait
                    d.armed         = 1'b0;
                    d.wake_v        = 1'b1;
                    d.cause[CZ_MON] = 1'b1;
                end else begin
                    d.sleep  = 1'b1;
                    d.brk    = wait_brk_i;
                    d.pstate = eff_state;
                end
            end else if (arm_valid_i) begin
                d.armed = 1'b1;
                d.line  = arm_addr_i[ADDR_W-1:OFS];
            end else if (store_hit) begin
                // R12: early store drops the arm
                d.armed = 1'b0;
            end
        end else if (wake_now) begin
            // R11: single report, priority monitor > interrupt > timer
            d.sleep  = 1'b0;
            d.brk    = 1'b0;
            d.pstate = PS_RUN;
            d.armed  = 1'b0;
            d.wake_v = 1'b1;
            if (store_hit)
                d.cause[CZ_MON] = 1'b1;
            else if (irq_unmasked_i || (irq_masked_i && q.brk))
                d.cause[CZ_IRQ] = 1'b1;
            else
                d.cause[CZ_TMR] = 1'b1;
        end
        // R13: commands during sleep fall through untouched
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pstate_o     = q.pstate;
    assign sleeping_o   = q.sleep;
    assign armed_o      = q.armed;
    assign wake_valid_o = q.wake_v;
    assign wake_cause_o = q.cause;

    a_r11_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> ($countones(wake_cause_o) == 1));

    a_r11_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_valid_o |-> (wake_cause_o == '0));

    a_r11_wake_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> !armed_o);

    a_r3_sleep_nonactive: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping_o |-> (pstate_o != PS_RUN));

    a_r1_awake_active: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping_o |-> (pstate_o == PS_RUN));

    a_r4_noarm_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid_o && wake_cause_o[CZ_NOARM]) |-> (!sleeping_o && $past(!sleeping_o)));

    a_r2_sleep_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping_o |-> armed_o);

    a_r8_priv_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleeping_o) && $past(wait_priv_i)) |-> (pstate_o <= PS_HALT));

    a_r9_user_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleeping_o) && $past(wait_user_i)) |-> (pstate_o <= PS_SUB2));

endmodule

// File: tb/sim_linewatch_wake.sv
module sim_linewatch_wake;
    localparam int AW = 32;
    localparam int TW = 32;
    localparam logic [3:0] C_MON = 4'b0001, C_IRQ = 4'b0010,
                           C_TMR = 4'b0100, C_NOA = 4'b1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm_valid_i = 0, wait_valid_i = 0, wait_brk_i = 0, wait_timed_i = 0;
    logic wait_user_i = 0, wait_priv_i = 0, cfg_lite_i = 0;
    logic snoop_valid_i = 0, snoop_wb_i = 0, snoop_cpu_i = 0;
    logic irq_unmasked_i = 0, irq_masked_i = 0, tick_i = 0;
    logic [AW-1:0] arm_addr_i = '0, snoop_addr_i = '0;
    logic [2:0] wait_state_i = '0;
    logic [TW-1:0] wait_deadline_i = '0, cfg_max_time_i = '0;
    logic [2:0] pstate_o;
    logic sleeping_o, armed_o, wake_valid_o;
    logic [3:0] wake_cause_o;

    int n_tests = 0, n_fail = 0;
    logic [3:0] exp_q[$];
    bit done = 0;

    always #2 clk = ~clk;

    linewatch_wake u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wake_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11 unexpected wake", int'(wake_cause_o), 0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk(wake_cause_o == e, "R11 wake cause", int'(wake_cause_o), int'(e));
            end
        end
    end

    task automatic expect_wake(input logic [3:0] c);
        exp_q.push_back(c);
    endtask

    task automatic do_arm(input logic [AW-1:0] a);
        @(negedge clk); arm_valid_i = 1; arm_addr_i = a;
        @(negedge clk); arm_valid_i = 0;
    endtask

    task automatic do_wait(input logic [2:0] st, input bit brk, input bit timed,
                           input int dl, input bit user, input bit priv);
        @(negedge clk);
        wait_valid_i = 1; wait_state_i = st; wait_brk_i = brk; wait_timed_i = timed;
        wait_deadline_i = dl; wait_user_i = user; wait_priv_i = priv;
        @(negedge clk); wait_valid_i = 0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input bit wb, input bit cpu);
        @(negedge clk); snoop_valid_i = 1; snoop_addr_i = a; snoop_wb_i = wb; snoop_cpu_i = cpu;
        @(negedge clk); snoop_valid_i = 0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_unmasked_i = 1;
        @(negedge clk); irq_unmasked_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1;
            @(negedge clk); tick_i = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(pstate_o == 0 && !sleeping_o && !armed_o && !wake_valid_o, "R1 reset",
            {pstate_o, sleeping_o, armed_o, wake_valid_o}, 0);

        // R2, R3, R6, R5
        do_arm(32'h1000_0040);
        chk(armed_o, "R2 armed", armed_o, 1);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        chk(sleeping_o && pstate_o == 3, "R3 enter halt", pstate_o, 3);
        do_store(32'h1000_0044, 0, 1);
        do_store(32'h1000_0048, 1, 0);
        do_store(32'h1000_0080, 1, 1);
        chk(sleeping_o, "R6 non-matching stores ignored", sleeping_o, 1);
        expect_wake(C_MON);
        do_store(32'h1000_007C, 1, 1);
        chk(!sleeping_o && pstate_o == 0 && !armed_o, "R5 line hit wakes",
            {sleeping_o, pstate_o, armed_o}, 0);

        // R4
        expect_wake(C_NOA);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        chk(!sleeping_o && pstate_o == 0, "R4 not armed stays active", pstate_o, 0);

        // R8, R7 masked without break flag
        do_arm(32'h2000_0000);
        do_wait(3'd6, 0, 0, 0, 0, 1);
        chk(pstate_o == 3, "R8 privilege clamp", pstate_o, 3);
        @(negedge clk); irq_masked_i = 1;
        repeat (3) @(negedge clk);
        chk(sleeping_o, "R7 masked irq ignored", sleeping_o, 1);
        irq_masked_i = 0;
        expect_wake(C_IRQ);
        pulse_irq();
        chk(!sleeping_o, "R7 unmasked irq wakes", sleeping_o, 0);

        // R3 deep state, R7 masked with break flag
        do_arm(32'h2000_0000);
        do_wait(3'd6, 1, 0, 0, 0, 0);
        chk(pstate_o == 6, "R3 deep state kept", pstate_o, 6);
        expect_wake(C_IRQ);
        @(negedge clk); irq_masked_i = 1;
        @(negedge clk); irq_masked_i = 0;
        chk(!sleeping_o, "R7 masked irq with break wakes", sleeping_o, 0);

        // R9 user caps
        do_arm(32'h3000_0000);
        do_wait(3'd5, 0, 0, 0, 1, 1);
        chk(pstate_o == 2, "R9 user cap", pstate_o, 2);
        expect_wake(C_IRQ); pulse_irq();
        cfg_lite_i = 1;
        do_arm(32'h3000_0000);
        do_wait(3'd2, 0, 0, 0, 1, 1);
        chk(pstate_o == 1, "R9 lite cap", pstate_o, 1);
        expect_wake(C_IRQ); pulse_irq();
        cfg_lite_i = 0;
        do_arm(32'h3000_0000);
        do_wait(3'd0, 0, 0, 0, 0, 0);
        chk(pstate_o == 1, "R3 request 0 resolves to 1", pstate_o, 1);
        expect_wake(C_IRQ); pulse_irq();

        // R10 timed deadline
        do_arm(32'h4000_0000);
        do_wait(3'd3, 0, 1, 3, 0, 0);
        ticks(2);
        chk(sleeping_o, "R10 before deadline", sleeping_o, 1);
        expect_wake(C_TMR);
        ticks(1);
        @(negedge clk);
        chk(!sleeping_o, "R10 deadline wake", sleeping_o, 0);

        // R10 OS max smaller than deadline
        cfg_max_time_i = 2;
        do_arm(32'h4000_0000);
        do_wait(3'd3, 0, 1, 10, 0, 0);
        ticks(1);
        chk(sleeping_o, "R10 min before", sleeping_o, 1);
        expect_wake(C_TMR);
        ticks(1);
        @(negedge clk);
        chk(!sleeping_o, "R10 OS max bounds deadline", sleeping_o, 0);

        // R10 OS max alone
        do_arm(32'h4000_0000);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        expect_wake(C_TMR);
        ticks(2);
        @(negedge clk);
        chk(!sleeping_o, "R10 OS max untimed wait", sleeping_o, 0);
        cfg_max_time_i = 0;

        // R10 no countdown
        do_arm(32'h4000_0000);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        ticks(5);
        chk(sleeping_o, "R10 no timer", sleeping_o, 1);
        expect_wake(C_IRQ); pulse_irq();

        // R11 priority monitor over interrupt
        do_arm(32'h5000_0000);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        expect_wake(C_MON);
        @(negedge clk);
        snoop_valid_i = 1; snoop_addr_i = 32'h5000_0010; snoop_wb_i = 1; snoop_cpu_i = 1;
        irq_unmasked_i = 1;
        @(negedge clk); snoop_valid_i = 0; irq_unmasked_i = 0;
        chk(!sleeping_o && !armed_o, "R11 priority wake", sleeping_o, 0);

        // R5 store in the same cycle as wait
        do_arm(32'h5000_0000);
        expect_wake(C_MON);
        @(negedge clk);
        wait_valid_i = 1; wait_state_i = 3; wait_priv_i = 0; wait_user_i = 0; wait_timed_i = 0;
        snoop_valid_i = 1; snoop_addr_i = 32'h5000_0020;
        @(negedge clk); wait_valid_i = 0; snoop_valid_i = 0;
        chk(!sleeping_o && pstate_o == 0, "R5 same-cycle store", pstate_o, 0);

        // R12 early store
        do_arm(32'h6000_0000);
        do_store(32'h6000_0008, 1, 1);
        chk(!armed_o, "R12 early store disarms", armed_o, 0);
        expect_wake(C_NOA);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        chk(!sleeping_o, "R12 wait returns at once", sleeping_o, 0);

        // R13 commands during sleep
        do_arm(32'h7000_0000);
        do_wait(3'd3, 0, 0, 0, 0, 0);
        do_arm(32'h7100_0000);
        do_wait(3'd1, 0, 0, 0, 0, 0);
        chk(sleeping_o && pstate_o == 3, "R13 wait ignored while sleeping", pstate_o, 3);
        expect_wake(C_IRQ); pulse_irq();
        chk(!armed_o, "R13 arm ignored while sleeping", armed_o, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 expected wakes seen", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=1 exp=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule